// File: doc/BRIEF.md
# Oversampling Serial Character Receiver

This block turns an asynchronous serial line into parallel characters. A free-running enable pulse, supplied from outside at sixteen times the bit rate, paces all of its timing. The input line first passes through a short synchroniser. While the line is idle the receiver waits for a low level. When it sees one, it waits half a bit time and samples the line again to confirm the start bit. It then samples each data bit at the centre of its bit cell, least significant bit first, and finally checks that the stop bit is at mark (high).

Each character is presented on a parallel output. A one-cycle strobe marks a good character, and a one-cycle error pulse marks a missing stop bit. A character whose data bits are all zero and whose stop bit is low is a line break, which is flagged by a third pulse that comes together with the error pulse. After an error, the receiver does not hunt for a new start bit until it has seen the line high. The character length, the oversampling ratio and the synchroniser depth are parameters.

Top module: `osrx_receiver`

## Requirements
- R1: While `rst` is high and after it is released, `rx_valid`, `rx_error` and `rx_break` are low and `rx_data` is zero until the first character completes.
- R2: A low line seen on a tick while hunting starts a check that samples the line again OVS/2 ticks later. If the line is high at that point, the receiver goes back to hunting and produces no output.
- R3: After the start bit is confirmed, the receiver takes each of the DATA_BITS data bits OVS ticks after the previous sample. It places them least significant bit first, so the first bit received lands in `rx_data[0]`.
- R4: `rx_data` changes only in the cycle in which `rx_valid` or `rx_error` is high, and it holds its value at all other times.
- R5: If the line is high at the stop sample (OVS ticks after the last data bit), `rx_valid` is high for exactly one cycle, one clock after that tick, and `rx_error` stays low.
- R6: If the line is low at the stop sample, `rx_error` is high for exactly one cycle, and `rx_valid` stays low.
- R7: `rx_break` pulses in the same cycle as `rx_error` when, and only when, the received data bits are all zero.
- R8: After a stop-bit error, the receiver does not start a new character until the line has been sampled high on a tick.
- R9: The line is sampled and timing advances only on cycles where `tick` is high. Without ticks, no output pulse occurs. The line input reaches the sampling logic through SYNC_STAGES flip-flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Oversampling enable, one pulse per 1/OVS bit time |
| rxd | input | 1 | Asynchronous serial line, high when idle |
| rx_data | output | DATA_BITS | Last received character |
| rx_valid | output | 1 | One-cycle pulse: character received with a good stop bit |
| rx_error | output | 1 | One-cycle pulse: stop bit was low |
| rx_break | output | 1 | One-cycle pulse with rx_error when all data bits were zero |

## Verification
The assertions check, on every cycle, the properties that hold at the outputs: the good and error pulses never overlap and last one cycle, a break always comes with an error and a zero character, the data output moves only with a pulse, and pulses follow a tick. The bench's scenarios are the only way to show the timing behaviour: the half-bit start confirmation that rejects glitches, centre sampling in LSB-first order, the wait for mark after an error, and the freeze when ticks stop. A behavioural model in the bench, compared on every clock, covers these.

// File: rtl/osrx_pkg.sv
package osrx_pkg;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_CONFIRM,
        ST_DATA,
        ST_STOP,
        ST_WAITMARK
    } rx_state_e;

    // Mark level of an idle line
    localparam logic LINE_IDLE = 1'b1;

    function automatic logic all_zero(input logic [63:0] v, input int unsigned n);
        logic z;
        z = 1'b1;
        for (int i = 0; i < 64; i++) begin
            if (i < n && v[i]) z = 1'b0;
        end
        return z;
    endfunction

endpackage

// File: rtl/osrx_sync.sv
module osrx_sync #(
    parameter int  STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= RESET_VAL;
                else     chain[0] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= RESET_VAL;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/osrx_timer.sv
module osrx_timer #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expire
);
    logic [W-1:0] cnt;

    // The count reaches zero on the tick that sees one remaining
    assign expire = tick && (cnt == W'(1));

    always_ff @(posedge clk) begin
        if (rst)                         cnt <= '0;
        else if (load)                   cnt <= load_val;
        else if (tick && cnt > W'(1))    cnt <= cnt - W'(1);
    end
endmodule

// File: rtl/osrx_shifter.sv
module osrx_shifter #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         din,
    output logic [N-1:0] q
);
    generate
        if (N == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst)           q <= '0;
                else if (shift_en) q <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst)           q <= '0;
                else if (shift_en) q <= {din, q[N-1:1]};
            end
        end
    endgenerate
endmodule

// File: rtl/osrx_receiver.sv
module osrx_receiver
    import osrx_pkg::*;
#(
    parameter int DATA_BITS   = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 rxd,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_valid,
    output logic                 rx_error,
    output logic                 rx_break
);
    localparam int CW   = $clog2(OVS + 1);
    localparam int BW   = $clog2(DATA_BITS + 1);
    localparam int HALF = OVS / 2;

    rx_state_e            state, state_n;
    logic [BW-1:0]        bits_left, bits_n;
    logic                 line;
    logic                 load, expire, shift_en;
    logic [CW-1:0]        load_val;
    logic [DATA_BITS-1:0] shreg;
    logic                 stop_done;

    osrx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(LINE_IDLE)) u_sync (
        .clk(clk), .rst(rst), .din(rxd), .dout(line)
    );

    osrx_timer #(.W(CW)) u_timer (
        .clk(clk), .rst(rst), .tick(tick),
        .load(load), .load_val(load_val), .expire(expire)
    );

    osrx_shifter #(.N(DATA_BITS)) u_shift (
        .clk(clk), .rst(rst), .shift_en(shift_en), .din(line), .q(shreg)
    );

    always_comb begin
        state_n   = state;
        bits_n    = bits_left;
        load      = 1'b0;
        load_val  = CW'(OVS);
        shift_en  = 1'b0;
        stop_done = 1'b0;
        unique case (state)
            ST_HUNT: begin
                if (tick && !line) begin
                    load     = 1'b1;
                    load_val = CW'(HALF);
                    state_n  = ST_CONFIRM;
                end
            end
            ST_CONFIRM: begin
                if (expire) begin
                    if (!line) begin
                        load    = 1'b1;
                        bits_n  = BW'(DATA_BITS);
                        state_n = ST_DATA;
                    end else begin
                        state_n = ST_HUNT;
                    end
                end
            end
            ST_DATA: begin
                if (expire) begin
                    shift_en = 1'b1;
                    load     = 1'b1;
                    bits_n   = bits_left - BW'(1);
                    if (bits_left == BW'(1)) state_n = ST_STOP;
                end
            end
            ST_STOP: begin
                if (expire) begin
                    stop_done = 1'b1;
                    state_n   = line ? ST_HUNT : ST_WAITMARK;
                end
            end
            ST_WAITMARK: begin
                if (tick && line) state_n = ST_HUNT;
            end
            default: state_n = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_HUNT;
            bits_left <= '0;
            rx_data   <= '0;
            rx_valid  <= 1'b0;
            rx_error  <= 1'b0;
            rx_break  <= 1'b0;
        end else begin
            state     <= state_n;
            bits_left <= bits_n;
            rx_valid  <= stop_done && line;
            rx_error  <= stop_done && !line;
            rx_break  <= stop_done && !line && all_zero(64'(shreg), DATA_BITS);
            if (stop_done) rx_data <= shreg;
        end
    end
endmodule

// File: rtl/osrx_receiver_chk.sv
module osrx_receiver_chk #(
    parameter int DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 tick,
    input logic [DATA_BITS-1:0] rx_data,
    input logic                 rx_valid,
    input logic                 rx_error,
    input logic                 rx_break
);
    // R5 / R6: good and error indications are exclusive
    p_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(rx_valid && rx_error));

    p_valid_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    p_error_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        rx_error |=> !rx_error);

    p_break_null_r7: assert property (@(posedge clk) disable iff (rst)
        rx_break |-> (rx_error && rx_data == '0));

    p_data_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_data) |-> (rx_valid || rx_error));

    p_pulse_after_tick_r9: assert property (@(posedge clk) disable iff (rst)
        (rx_valid || rx_error) |-> $past(tick));
endmodule

bind osrx_receiver osrx_receiver_chk #(.DATA_BITS(DATA_BITS)) u_chk (
    .clk(clk), .rst(rst), .tick(tick), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_error(rx_error), .rx_break(rx_break)
);

// File: tb/osrx_receiver_bench.sv
`timescale 1ns/1ps
module osrx_receiver_bench;
    localparam int N    = 8;
    localparam int OVS  = 16;
    localparam int TDIV = 3;
    localparam int BITC = OVS * TDIV;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tick = 1'b0;
    logic         rxd = 1'b1;
    logic [N-1:0] rx_data;
    logic         rx_valid, rx_error, rx_break;

    int n_checks = 0, n_fail = 0;
    int n_valid = 0, n_err = 0, n_brk = 0;
    bit tick_en = 1'b1;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    osrx_receiver #(.DATA_BITS(N), .OVS(OVS), .SYNC_STAGES(2)) u_osrx_receiver (
        .clk(clk), .rst(rst), .tick(tick), .rxd(rxd),
        .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_error(rx_error), .rx_break(rx_break)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: line history, tick countdown, bit queue
    int     ph = 0;
    int     left = 0;
    bit     q[$];
    bit     h1 = 1'b1, h2 = 1'b1;
    bit     e_valid = 0, e_err = 0, e_brk = 0;
    int     e_data = 0;

    always @(posedge clk) begin
        bit s;
        int b;
        s = h2;
        e_valid = 0; e_err = 0; e_brk = 0;
        if (rst) begin
            ph = 0; e_data = 0; h1 = 1; h2 = 1; q.delete();
        end else begin
            if (tick) begin
                case (ph)
                    0: if (!s) begin ph = 1; left = OVS / 2; end
                    1: begin
                        left--;
                        if (left == 0) begin
                            if (!s) begin ph = 2; left = OVS; q.delete(); end
                            else ph = 0;
                        end
                    end
                    2: begin
                        left--;
                        if (left == 0) begin
                            left = OVS;
                            if (q.size() < N) q.push_back(s);
                            else begin
                                b = 0;
                                foreach (q[i]) if (q[i]) b |= (1 << i);
                                e_data = b;
                                if (s) begin e_valid = 1; ph = 0; end
                                else begin e_err = 1; e_brk = (b == 0); ph = 3; end
                            end
                        end
                    end
                    default: if (s) ph = 0;
                endcase
            end
            h2 = h1;
            h1 = rxd;
        end
    end

    // Every-clock comparison away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(rx_valid == e_valid, "R5 rx_valid", rx_valid, e_valid);
            check(rx_error == e_err,   "R6 rx_error", rx_error, e_err);
            check(rx_break == e_brk,   "R7 rx_break", rx_break, e_brk);
            check(rx_data == N'(e_data), "R3 rx_data", rx_data, e_data);
            if (rx_valid) n_valid++;
            if (rx_error) n_err++;
            if (rx_break) n_brk++;
        end
    end

    // Tick source
    initial begin
        int d = 0;
        forever begin
            @(negedge clk);
            d = (d + 1) % TDIV;
            tick = tick_en && (d == 0);
        end
    end

    task automatic hold(input bit v, input int clocks);
        rxd = v;
        repeat (clocks) @(negedge clk);
    endtask

    task automatic frame(input logic [N-1:0] b, input bit stop);
        hold(1'b0, BITC);
        for (int i = 0; i < N; i++) hold(b[i], BITC);
        hold(stop, BITC);
        hold(1'b1, 2 * BITC);
    endtask

    task automatic expect_counts(input string tag, input int v0, input int e0, input int b0,
                                 input int dv, input int de, input int db);
        check(n_valid - v0 == dv, {tag, " valid count"}, n_valid - v0, dv);
        check(n_err - e0 == de,   {tag, " error count"}, n_err - e0, de);
        check(n_brk - b0 == db,   {tag, " break count"}, n_brk - b0, db);
    endtask

    initial begin
        int v0, e0, b0;
        repeat (5) @(negedge clk);
        // R1: reset state
        check(rx_valid == 0 && rx_error == 0 && rx_break == 0, "R1 pulses in reset",
              {rx_valid, rx_error, rx_break}, 0);
        check(rx_data == 0, "R1 data in reset", rx_data, 0);
        rst = 1'b0;
        repeat (20) @(negedge clk);
        check(rx_data == 0 && !rx_valid, "R1 idle after reset", rx_data, 0);

        // R3 R5: good characters, LSB first
        v0 = n_valid; e0 = n_err; b0 = n_brk;
        frame(8'h55, 1); frame(8'hA3, 1); frame(8'h00, 1); frame(8'hFF, 1); frame(8'h01, 1);
        expect_counts("R5 good frames", v0, e0, b0, 5, 0, 0);
        check(rx_data == 8'h01, "R3 lsb first", rx_data, 8'h01);

        // R2: short low glitch is rejected at the half-bit check
        v0 = n_valid; e0 = n_err; b0 = n_brk;
        hold(1'b0, 3 * TDIV);
        hold(1'b1, 3 * BITC);
        expect_counts("R2 glitch", v0, e0, b0, 0, 0, 0);
        check(rx_data == 8'h01, "R4 data held after glitch", rx_data, 8'h01);

        // R6: bad stop with nonzero data
        v0 = n_valid; e0 = n_err; b0 = n_brk;
        frame(8'h3C, 0);
        expect_counts("R6 bad stop", v0, e0, b0, 0, 1, 0);
        check(rx_data == 8'h3C, "R6 data on error", rx_data, 8'h3C);

        // R7 R8: break held for two character times, then mark
        v0 = n_valid; e0 = n_err; b0 = n_brk;
        hold(1'b0, 2 * (N + 2) * BITC);
        hold(1'b1, 2 * BITC);
        expect_counts("R7 R8 break", v0, e0, b0, 0, 1, 1);
        check(rx_data == 0, "R7 null data", rx_data, 0);

        // R8: receiver hunts again after mark
        v0 = n_valid; e0 = n_err; b0 = n_brk;
        frame(8'h96, 1);
        expect_counts("R8 recover", v0, e0, b0, 1, 0, 0);
        check(rx_data == 8'h96, "R8 data after recover", rx_data, 8'h96);

        // R9: no ticks, line low: nothing happens
        v0 = n_valid; e0 = n_err; b0 = n_brk;
        tick_en = 1'b0;
        hold(1'b0, 20 * BITC);
        hold(1'b1, 10);
        tick_en = 1'b1;
        hold(1'b1, 2 * BITC);
        expect_counts("R9 no ticks", v0, e0, b0, 0, 0, 0);
        check(rx_data == 8'h96, "R9 data held", rx_data, 8'h96);

        // R6 R7: bad stop on a zero character immediately followed by a frame
        v0 = n_valid; e0 = n_err; b0 = n_brk;
        frame(8'h00, 0); frame(8'h7E, 1);
        expect_counts("R7 null bad stop", v0, e0, b0, 1, 1, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        done = 1'b1;
        n_checks++;
        n_fail++;
        $display("FAIL R9 watchdog actual=timeout expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule